// File: doc/BRIEF.md
# Asynchronous Memory-Bus Cycle Sequencer

This block turns one-at-a-time read and write requests from an on-chip bus into cycles on an external asynchronous memory bus, such as flash, SRAM or simple peripherals. The external space is split into up to eight regions. The top bits of the request address select a region, and each region has a 32-bit configuration word. That word sets whether the region is live and whether writes are allowed. It sets the bus width (8 or 16 bits), whether address and data share the data lines, the region size, and the length of each of the five cycle phases.

A legal request runs through five phases in a fixed order: address, setup, strobe, hold and recovery. Each phase lasts its programmed count plus one clock. Chip select is asserted from setup to hold, and the read or write strobe is asserted only during the strobe phase. A request that breaks a region rule drives no external signal. It completes on the next clock with an error flag set. Configuration words are loaded through a word-wide write port, one word per region, at byte offset region × 4.

Top module: `exb_ctrl`

## Requirements
- R1: After reset all chip selects (active low) are high, output-enable and write-enable are high, the data lines are not driven, and busy and rspDone are low.
- R2: Address bits [26:24] of a request select the region. During setup, strobe and hold only that region's chip-select line is low. No line is low in any other phase.
- R3: A legal access occupies (tAddr+1), (tSetup+1), (tStrobe+1), (tHold+1) and (tRecov+1) clocks in that order. rspDone is high for exactly one clock right after recovery. The timing fields are: bits 29:28 address, 27:26 setup, 25:22 strobe, 21:20 hold and 19:16 recovery.
- R4: A read drives oeN low only during the strobe phase. It returns on rspRdata the data lines as sampled at the end of the last strobe clock.
- R5: A write drives weN low only during the strobe phase. On a non-multiplexed bus it drives the write data from setup through hold, and nowhere else.
- R6: If configuration bit 31 is clear, the region is disabled. A request to it produces rspDone with rspErr one clock after acceptance, and asserts no chip select.
- R7: A write to a region whose bit 1 is clear completes with an error and no strobe. Reads from that region still work.
- R8: Only cycle style 0 in bits 15:14 is carried out. Codes 1 and 2 (and 3) complete with an error.
- R9: Size code n in bits 13:10 sets the region to 512 << n bytes. A request offset at or beyond that size completes with an error.
- R10: With bit 0 set (8-bit bus), byte requests use data lines [7:0]. The full byte offset goes out on extAddr and reads return {8'h00, data[7:0]}. Halfword requests complete with an error.
- R11: On a 16-bit bus, extAddr carries the offset with bit 0 cleared, and a halfword request with an odd offset fails. A byte read is allowed only when bit 6 is set, and returns the upper lane for an odd offset and the lower lane for an even one. A byte write fails.
- R12: With bit 4 set (multiplexed), the address offset [15:0] is driven on the data lines during the address phase. From setup onward a read leaves the lines undriven and a write drives its data.
- R13: A configuration write at byte offset 4·k loads region k's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration word write strobe |
| cfgAddr | input | 5 | Byte offset of the configuration word (region × 4) |
| cfgData | input | 32 | Configuration word |
| reqValid | input | 1 | Request, accepted when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = halfword |
| reqAddr | input | 27 | Region index [26:24] and byte offset [23:0] |
| reqWdata | input | 16 | Write data (byte in [7:0]) |
| busy | output | 1 | An access is in progress |
| rspDone | output | 1 | One-clock completion pulse |
| rspErr | output | 1 | Completion was a rejected request |
| rspRdata | output | 16 | Read data, held until the next read |
| csN | output | 8 | Chip selects, active low, one per region |
| extAddr | output | 24 | External address |
| oeN | output | 1 | Output enable (read strobe), active low |
| weN | output | 1 | Write enable, active low |
| dataOut | output | 16 | Data lines when driven |
| dataOe | output | 1 | Data lines driven by this block |
| dataIn | input | 16 | Data lines as received |

## Verification
The assertions check, on every clock, the properties that hold in every cycle:
- at most one chip select is low;
- a strobe occurs only inside an asserted chip select, and never both strobes together;
- a write strobe always has data driven;
- the bus is quiet when the block is idle;
- an error completion never shows a chip select;
- the completion pulse lasts one clock.

Only the directed scenarios can show the rest: the per-phase clock counts, the sampling instant for read data, the lane selection and the address forms, and the rejection rules for each configuration field. Each of these depends on the programmed word and on the request.

// File: rtl/exb_pkg.sv
package exb_pkg;

  localparam int EXB_DATA_W = 16;

  // Configuration word layout; the bit positions are part of the programming model.
  typedef struct packed {
    logic       en;        // 31
    logic       rsv30;     // 30
    logic [1:0] tAddr;     // 29:28
    logic [1:0] tSetup;    // 27:26
    logic [3:0] tStrobe;   // 25:22
    logic [1:0] tHold;     // 21:20
    logic [3:0] tRecov;    // 19:16
    logic [1:0] style;     // 15:14
    logic [3:0] sizeCode;  // 13:10
    logic [2:0] rsv9;      // 9:7
    logic       byteRd16;  // 6
    logic       rsv5;      // 5
    logic       muxMode;   // 4
    logic [1:0] rsv3;      // 3:2
    logic       wrEn;      // 1
    logic       bus8;      // 0
  } regionCfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STRB, PH_HOLD, PH_RECV, PH_DONE
  } phase_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadReq;
    logic addrPh;
    logic csOn;
    logic strobeOn;
    logic dataPh;
    logic capture;
  } busStrobe_t;

endpackage

// File: rtl/exb_control.sv
module exb_control
  import exb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFault,
  input  logic [1:0] tAddrSel,
  input  logic [1:0] tSetup,
  input  logic [3:0] tStrobe,
  input  logic [1:0] tHold,
  input  logic [3:0] tRecov,
  output busStrobe_t strb,
  output logic       busy,
  output logic       rspDone,
  output logic       rspErr
);

  phase_e     state, nState;
  logic [3:0] cnt, nCnt;
  logic       faultQ, nFault;
  logic       cntZero;

  assign cntZero = (cnt == 4'd0);

  always_comb begin
    nState = state;
    nCnt   = cnt;
    nFault = faultQ;
    unique case (state)
      PH_IDLE: begin
        if (reqValid) begin
          nFault = reqFault;
          if (reqFault) begin
            nState = PH_DONE;
          end else begin
            nState = PH_ADDR;
            nCnt   = {2'b00, tAddrSel};
          end
        end
      end
      PH_ADDR: begin
        if (cntZero) begin
          nState = PH_SETUP;
          nCnt   = {2'b00, tSetup};
        end else nCnt = cnt - 4'd1;
      end
      PH_SETUP: begin
        if (cntZero) begin
          nState = PH_STRB;
          nCnt   = tStrobe;
        end else nCnt = cnt - 4'd1;
      end
      PH_STRB: begin
        if (cntZero) begin
          nState = PH_HOLD;
          nCnt   = {2'b00, tHold};
        end else nCnt = cnt - 4'd1;
      end
      PH_HOLD: begin
        if (cntZero) begin
          nState = PH_RECV;
          nCnt   = tRecov;
        end else nCnt = cnt - 4'd1;
      end
      PH_RECV: begin
        if (cntZero) nState = PH_DONE;
        else nCnt = cnt - 4'd1;
      end
      PH_DONE: begin
        nState = PH_IDLE;
        nFault = 1'b0;
      end
      default: nState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= 4'd0;
      faultQ <= 1'b0;
    end else begin
      state  <= nState;
      cnt    <= nCnt;
      faultQ <= nFault;
    end
  end

  always_comb begin
    strb.loadReq  = (state == PH_IDLE) && reqValid && !reqFault;
    strb.addrPh   = (state == PH_ADDR);
    strb.csOn     = (state == PH_SETUP) || (state == PH_STRB) || (state == PH_HOLD);
    strb.strobeOn = (state == PH_STRB);
    strb.dataPh   = strb.csOn;
    strb.capture  = (state == PH_STRB) && cntZero;
  end

  assign busy    = (state != PH_IDLE);
  assign rspDone = (state == PH_DONE);
  assign rspErr  = (state == PH_DONE) && faultQ;

endmodule

// File: rtl/exb_datapath.sv
module exb_datapath
  import exb_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int OFF_W  = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [$clog2(NUM_CS)+1:0] cfgAddr,
  input  logic [31:0]           cfgData,
  input  logic                  reqWrite,
  input  logic                  reqByte,
  input  logic [$clog2(NUM_CS)+OFF_W-1:0] reqAddr,
  input  logic [EXB_DATA_W-1:0] reqWdata,
  input  busStrobe_t            strb,
  input  logic [EXB_DATA_W-1:0] dataIn,
  output regionCfg_t            selCfg,
  output regionCfg_t            actCfg,
  output logic                  reqFault,
  output logic [NUM_CS-1:0]     csN,
  output logic [OFF_W-1:0]      extAddr,
  output logic                  oeN,
  output logic                  weN,
  output logic [EXB_DATA_W-1:0] dataOut,
  output logic                  dataOe,
  output logic [EXB_DATA_W-1:0] rspRdata
);

  localparam int CS_W    = $clog2(NUM_CS);
  localparam int CFG_AW  = CS_W + 2;
  localparam int HA_W    = CS_W + OFF_W;
  localparam logic [4:0] SIZE_BASE = 5'd9;  // 512-byte minimum region

  regionCfg_t cfgArr [NUM_CS];

  logic [CS_W-1:0]  cfgIdx;
  logic [CS_W-1:0]  selIdx;
  logic [OFF_W-1:0] selOff;
  logic [31:0]      offExt;
  logic [4:0]       sizeShift;
  logic             sizeFault, widthFault;

  assign cfgIdx = cfgAddr[CFG_AW-1:2];
  assign selIdx = reqAddr[HA_W-1:OFF_W];
  assign selOff = reqAddr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CS; i++) cfgArr[i] <= '0;
    end else if (cfgWe) begin
      cfgArr[cfgIdx] <= regionCfg_t'(cfgData);
    end
  end

  // Request screening against the addressed region's word
  assign selCfg    = cfgArr[selIdx];
  assign offExt    = 32'(selOff);
  assign sizeShift = SIZE_BASE + {1'b0, selCfg.sizeCode};
  assign sizeFault = |(offExt >> sizeShift);

  always_comb begin
    if (selCfg.bus8) widthFault = !reqByte;
    else if (reqByte) widthFault = reqWrite || !selCfg.byteRd16;
    else widthFault = selOff[0];
  end

  assign reqFault = !selCfg.en || (selCfg.style != 2'd0) || sizeFault ||
                    (reqWrite && !selCfg.wrEn) || widthFault;

  // Latched access
  logic [CS_W-1:0]       actIdx;
  logic [OFF_W-1:0]      actAddr;
  logic                  actWrite, actByte, actLane;
  logic [EXB_DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg   <= '0;
      actIdx   <= '0;
      actAddr  <= '0;
      actWrite <= 1'b0;
      actByte  <= 1'b0;
      actLane  <= 1'b0;
      wdataQ   <= '0;
    end else if (strb.loadReq) begin
      actCfg   <= selCfg;
      actIdx   <= selIdx;
      actAddr  <= selCfg.bus8 ? selOff : {selOff[OFF_W-1:1], 1'b0};
      actWrite <= reqWrite;
      actByte  <= reqByte;
      actLane  <= selOff[0];
      wdataQ   <= selCfg.bus8 ? {8'h00, reqWdata[7:0]} : reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.capture && !actWrite) begin
      if (actCfg.bus8) rdataQ <= {8'h00, dataIn[7:0]};
      else if (actByte) rdataQ <= {8'h00, actLane ? dataIn[15:8] : dataIn[7:0]};
      else rdataQ <= dataIn;
    end
  end

  // Pin drive
  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_cs
      localparam logic [CS_W-1:0] IDX = CS_W'(g);
      assign csN[g] = !(strb.csOn && (actIdx == IDX));
    end
  endgenerate

  logic muxAddr;
  assign muxAddr  = strb.addrPh && actCfg.muxMode;
  assign oeN      = !(strb.strobeOn && !actWrite);
  assign weN      = !(strb.strobeOn && actWrite);
  assign dataOe   = muxAddr || (strb.dataPh && actWrite);
  assign dataOut  = muxAddr ? actAddr[EXB_DATA_W-1:0] : wdataQ;
  assign extAddr  = actAddr;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/exb_ctrl.sv
module exb_ctrl
  import exb_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int OFF_W  = 24
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [$clog2(NUM_CS)+1:0]         cfgAddr,
  input  logic [31:0]                       cfgData,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic                              reqByte,
  input  logic [$clog2(NUM_CS)+OFF_W-1:0]   reqAddr,
  input  logic [15:0]                       reqWdata,
  output logic                              busy,
  output logic                              rspDone,
  output logic                              rspErr,
  output logic [15:0]                       rspRdata,
  output logic [NUM_CS-1:0]                 csN,
  output logic [OFF_W-1:0]                  extAddr,
  output logic                              oeN,
  output logic                              weN,
  output logic [15:0]                       dataOut,
  output logic                              dataOe,
  input  logic [15:0]                       dataIn
);

  busStrobe_t strb;
  regionCfg_t selCfg, actCfg;
  logic       reqFault;

  exb_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqFault (reqFault),
    .tAddrSel (selCfg.tAddr),
    .tSetup   (actCfg.tSetup),
    .tStrobe  (actCfg.tStrobe),
    .tHold    (actCfg.tHold),
    .tRecov   (actCfg.tRecov),
    .strb     (strb),
    .busy     (busy),
    .rspDone  (rspDone),
    .rspErr   (rspErr)
  );

  exb_datapath #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .reqWrite (reqWrite),
    .reqByte  (reqByte),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strb     (strb),
    .dataIn   (dataIn),
    .selCfg   (selCfg),
    .actCfg   (actCfg),
    .reqFault (reqFault),
    .csN      (csN),
    .extAddr  (extAddr),
    .oeN      (oeN),
    .weN      (weN),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/exb_ctrl_chk.sv
module exb_ctrl_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic              oeN,
  input logic              weN,
  input logic              dataOe,
  input logic              busy,
  input logic              rspDone,
  input logic              rspErr
);

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R4
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (!(&csN) && weN));

  // R5
  we_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (dataOe && !(&csN)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((&csN) && oeN && weN && !dataOe && !rspDone));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspDone && (&csN) && !dataOe));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind exb_ctrl exb_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .oeN     (oeN),
  .weN     (weN),
  .dataOe  (dataOe),
  .busy    (busy),
  .rspDone (rspDone),
  .rspErr  (rspErr)
);

// File: tb/exb_ctrl_bench.sv
module exb_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqByte = 1'b0;
  logic [26:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [7:0]  csN;
  logic [23:0] extAddr;
  logic        oeN, weN;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [15:0] dataIn = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  exb_ctrl u_exb_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqByte(reqByte), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busy(busy), .rspDone(rspDone), .rspErr(rspErr),
    .rspRdata(rspRdata), .csN(csN), .extAddr(extAddr), .oeN(oeN), .weN(weN),
    .dataOut(dataOut), .dataOe(dataOe), .dataIn(dataIn)
  );

  // Observations of the last access
  int          aCnt, sCnt, stCnt, hCnt, rCnt;
  logic [7:0]  csSeen;
  bit          sawOe, sawWe, gotErr, addrOeAll, midOeAll, midOeAny, outerOe;
  logic [15:0] addrOut, strobeOut, gotRdata;
  logic [23:0] strobeAddr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input bit en, input int t1, input int t2,
      input int t3, input int t4, input int t5, input int style, input int size,
      input bit rd16, input bit mux, input bit wr, input bit b8);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[29:28] = 2'(t1); w[27:26] = 2'(t2); w[25:22] = 4'(t3);
    w[21:20] = 2'(t4); w[19:16] = 4'(t5); w[15:14] = 2'(style); w[13:10] = 4'(size);
    w[6] = rd16; w[4] = mux; w[1] = wr; w[0] = b8;
    return w;
  endfunction

  // R13: region k's word sits at byte offset 4*k
  task automatic cfgWrite(input int region, input logic [31:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'(region * 4); cfgData = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runAccess(input int region, input int off, input bit wr, input bit bt,
      input logic [15:0] wd, input logic [15:0] good, input int expStrobe);
    int ph;
    bit csAct, str;
    aCnt = 0; sCnt = 0; stCnt = 0; hCnt = 0; rCnt = 0; csSeen = '0;
    sawOe = 0; sawWe = 0; gotErr = 0; addrOeAll = 1; midOeAll = 1; midOeAny = 0;
    outerOe = 0; addrOut = '0; strobeOut = '0; strobeAddr = '0;
    ph = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqByte = bt;
    reqAddr = {3'(region), 24'(off)}; reqWdata = wd; dataIn = ~good;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rspDone) break;
      csAct = (csN != 8'hFF);
      str = !oeN || !weN;
      csSeen = csSeen | ~csN;
      if (str) begin
        ph = 2; stCnt++;
        if (!oeN) sawOe = 1;
        if (!weN) sawWe = 1;
        strobeOut = dataOut; strobeAddr = extAddr;
        if (!dataOe) midOeAll = 0; else midOeAny = 1;
        dataIn = (stCnt == expStrobe) ? good : ~good;
      end else if (csAct) begin
        if (ph <= 1) begin ph = 1; sCnt++; end else begin ph = 3; hCnt++; end
        if (!dataOe) midOeAll = 0; else midOeAny = 1;
      end else if (ph == 0) begin
        aCnt++;
        if (!dataOe) addrOeAll = 0;
        addrOut = dataOut;
      end else begin
        ph = 4; rCnt++;
        if (dataOe) outerOe = 1;
      end
      @(negedge clk);
    end
    gotErr = rspErr;
    chk("R3 completion seen", 32'(rspDone), 32'd1);
    gotRdata = rspRdata;
  endtask

  task automatic checkPhases(input string tag, input int e1, input int e2, input int e3,
      input int e4, input int e5);
    chk({tag, " address clocks"}, 32'(aCnt), 32'(e1));
    chk({tag, " setup clocks"}, 32'(sCnt), 32'(e2));
    chk({tag, " strobe clocks"}, 32'(stCnt), 32'(e3));
    chk({tag, " hold clocks"}, 32'(hCnt), 32'(e4));
    chk({tag, " recovery clocks"}, 32'(rCnt), 32'(e5));
  endtask

  task automatic testReset();
    chk("R1 csN", 32'(csN), 32'hFF);
    chk("R1 oeN/weN", {30'd0, oeN, weN}, 32'd3);
    chk("R1 dataOe", 32'(dataOe), 32'd0);
    chk("R1 busy/done", {30'd0, busy, rspDone}, 32'd0);
  endtask

  task automatic testRead();
    cfgWrite(2, mkCfg(1, 1, 2, 3, 1, 2, 0, 15, 0, 0, 1, 0));
    runAccess(2, 'h1234, 0, 0, 16'h0, 16'hBEEF, 4);
    checkPhases("R3 read", 2, 3, 4, 2, 3);
    chk("R2 only region 2 selected", 32'(csSeen), 32'h04);
    chk("R4 oe seen, no we", {30'd0, sawOe, sawWe}, 32'd2);
    chk("R4 read data at last strobe clock", 32'(gotRdata), 32'hBEEF);
    chk("R11 16-bit address", 32'(strobeAddr), 32'h1234);
    chk("R4 no error", 32'(gotErr), 32'd0);
  endtask

  task automatic testWrite();
    cfgWrite(5, mkCfg(1, 0, 0, 0, 0, 0, 0, 15, 0, 0, 1, 0));
    runAccess(5, 'h10, 1, 0, 16'h5A3C, 16'h0, 1);
    checkPhases("R3 write min", 1, 1, 1, 1, 1);
    chk("R5 we seen, no oe", {30'd0, sawOe, sawWe}, 32'd1);
    chk("R5 data driven setup..hold", 32'(midOeAll), 32'd1);
    chk("R5 data value", 32'(strobeOut), 32'h5A3C);
    chk("R5 not driven in address/recovery", {30'd0, addrOeAll, outerOe}, 32'd0);
    chk("R2 only region 5 selected", 32'(csSeen), 32'h20);
  endtask

  task automatic testMaxTiming();
    cfgWrite(7, mkCfg(1, 3, 3, 15, 3, 15, 0, 15, 0, 0, 1, 0));
    runAccess(7, 'h40, 0, 0, 16'h0, 16'h1357, 16);
    checkPhases("R3 max", 4, 4, 16, 4, 16);
    chk("R4 read data max timing", 32'(gotRdata), 32'h1357);
  endtask

  task automatic testDisabled();
    cfgWrite(1, mkCfg(0, 1, 1, 1, 1, 1, 0, 15, 0, 0, 1, 0));
    runAccess(1, 'h0, 0, 0, 16'h0, 16'h0, 1);
    chk("R6 disabled error", 32'(gotErr), 32'd1);
    chk("R6 no chip select", 32'(csSeen), 32'h00);
    chk("R6 done next clock", 32'(aCnt + sCnt + stCnt + hCnt + rCnt), 32'd0);
  endtask

  task automatic testWriteBlock();
    cfgWrite(3, mkCfg(1, 0, 0, 1, 0, 0, 0, 15, 0, 0, 0, 0));
    runAccess(3, 'h20, 1, 0, 16'hFFFF, 16'h0, 1);
    chk("R7 write blocked error", 32'(gotErr), 32'd1);
    chk("R7 no strobe", {30'd0, sawOe, sawWe}, 32'd0);
    runAccess(3, 'h20, 0, 0, 16'h0, 16'h2468, 2);
    chk("R7 read still allowed", 32'(gotErr), 32'd0);
    chk("R13 region 3 word at offset 0x0C", 32'(csSeen), 32'h08);
    chk("R7 read data", 32'(gotRdata), 32'h2468);
  endtask

  task automatic testStyle();
    cfgWrite(4, mkCfg(1, 0, 0, 0, 0, 0, 1, 15, 0, 0, 1, 0));
    runAccess(4, 'h0, 0, 0, 16'h0, 16'h0, 1);
    chk("R8 style 1 rejected", {31'd0, gotErr}, 32'd1);
    cfgWrite(4, mkCfg(1, 0, 0, 0, 0, 0, 2, 15, 0, 0, 1, 0));
    runAccess(4, 'h0, 0, 0, 16'h0, 16'h0, 1);
    chk("R8 style 2 rejected", {31'd0, gotErr}, 32'd1);
    chk("R8 no chip select", 32'(csSeen), 32'h00);
  endtask

  task automatic testSize();
    cfgWrite(6, mkCfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    runAccess(6, 'h1FE, 0, 0, 16'h0, 16'h0F0F, 1);
    chk("R9 last halfword of 512B accepted", 32'(gotErr), 32'd0);
    runAccess(6, 'h200, 0, 0, 16'h0, 16'h0, 1);
    chk("R9 offset 512 rejected", 32'(gotErr), 32'd1);
    cfgWrite(6, mkCfg(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    runAccess(6, 'h200, 0, 0, 16'h0, 16'h0, 1);
    chk("R9 offset 512 fits 1KB", 32'(gotErr), 32'd0);
  endtask

  task automatic testBus8();
    cfgWrite(0, mkCfg(1, 0, 0, 1, 0, 0, 0, 15, 0, 0, 1, 1));
    runAccess(0, 'h33, 0, 1, 16'h0, 16'hABCD, 2);
    chk("R10 byte read low lane", 32'(gotRdata), 32'h00CD);
    chk("R10 full byte address", 32'(strobeAddr), 32'h33);
    runAccess(0, 'h34, 0, 0, 16'h0, 16'h0, 1);
    chk("R10 halfword rejected", 32'(gotErr), 32'd1);
    runAccess(0, 'h35, 1, 1, 16'h77EE, 16'h0, 1);
    chk("R10 byte write low lane", 32'(strobeOut), 32'h00EE);
  endtask

  task automatic testByte16();
    cfgWrite(2, mkCfg(1, 0, 0, 0, 0, 0, 0, 15, 1, 0, 1, 0));
    runAccess(2, 'h101, 0, 1, 16'h0, 16'hABCD, 1);
    chk("R11 odd byte upper lane", 32'(gotRdata), 32'h00AB);
    chk("R11 address bit 0 cleared", 32'(strobeAddr), 32'h100);
    runAccess(2, 'h100, 0, 1, 16'h0, 16'hABCD, 1);
    chk("R11 even byte lower lane", 32'(gotRdata), 32'h00CD);
    runAccess(2, 'h100, 1, 1, 16'h1111, 16'h0, 1);
    chk("R11 byte write rejected", 32'(gotErr), 32'd1);
    runAccess(2, 'h103, 0, 0, 16'h0, 16'h0, 1);
    chk("R11 odd halfword rejected", 32'(gotErr), 32'd1);
    cfgWrite(2, mkCfg(1, 0, 0, 0, 0, 0, 0, 15, 0, 0, 1, 0));
    runAccess(2, 'h100, 0, 1, 16'h0, 16'h0, 1);
    chk("R11 byte read without permission rejected", 32'(gotErr), 32'd1);
  endtask

  task automatic testMux();
    cfgWrite(5, mkCfg(1, 1, 1, 1, 1, 1, 0, 15, 0, 1, 1, 0));
    runAccess(5, 'h4320, 0, 0, 16'h0, 16'h9999, 2);
    chk("R12 address driven in address phase", 32'(addrOeAll), 32'd1);
    chk("R12 address on data lines", 32'(addrOut), 32'h4320);
    chk("R12 read released from setup", {30'd0, midOeAny, outerOe}, 32'd0);
    chk("R12 read data", 32'(gotRdata), 32'h9999);
    runAccess(5, 'h4320, 1, 0, 16'hC0DE, 16'h0, 2);
    chk("R12 write data driven from setup", 32'(midOeAll), 32'd1);
    chk("R12 write data value", 32'(strobeOut), 32'hC0DE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead();
    testWrite();
    testMaxTiming();
    testDisabled();
    testWriteBlock();
    testStyle();
    testSize();
    testBus8();
    testByte16();
    testMux();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule